// File: doc/BRIEF.md
# Programmable CPU Address Decode Windows

This block decodes every 32-bit CPU address against a bank of fourteen programmable windows. Each window holds a base, a size expressed as a mask of 64 KB units, a 4-bit target code and an 8-bit attribute. When an address falls inside an enabled window, the block tags it with that window's target and attribute and forwards it downstream. The lowest eight windows can also translate the address into a different region. An address that falls inside no window is flagged as a miss.

Software programs the windows through a word-wide register port. The lower eight windows sit in a low register region at a 16-byte stride. The other six sit in a second region starting at offset 0x900. Each window has a control word, a base word and, on the lower eight only, two translation words. Decode results and register read data are both registered.

Top module: `addr_decode_windows`

## Requirements
- R1: While reset is high and on the first cycle after it, dec_valid and dec_miss are 0. After reset, every register reads back as zero.
- R2: Window n (n < 8) is at byte offset n*0x10. Window n (8 <= n < 14) is at 0x900 + (n-8)*0x10. Within a window, +0x0 is control, +0x4 is base, +0x8 is translation-low and +0xC is translation-high. Read data appears one cycle after reg_addr is presented.
- R3: The control word keeps bit 0 (enable), bits 7:4 (target), bits 15:8 (attribute) and bits 31:16 (size-1 in 64 KB units), and reads its other bits as 0. The base and translation-low words keep only bits 31:16. Translation-high keeps all 32 bits.
- R4: An address hits an enabled window when its bits 31:16 equal the base bits 31:16 at every position where the size field is 0. On a hit, dec_target and dec_attr carry the window's fields.
- R5: A window whose enable bit is 0 never hits, even when its other fields are set.
- R6: When several windows hit, the lowest-numbered one supplies the result.
- R7: On a miss, dec_miss is 1, dec_target and dec_attr are 0, and dec_addr equals the input address.
- R8: On a hit in windows 0-7, dec_addr[31:16] is (translation-low & ~size) | (addr & size) on bits 31:16, and dec_addr[15:0] equals addr[15:0].
- R9: Windows 8-13 pass the address unchanged. Their +0x8 and +0xC offsets read as 0, and writes to those offsets are ignored.
- R10: dec_valid is cpu_valid delayed by one cycle, and the decode result for an address is on the outputs one cycle after it is presented.
- R11: A register write takes effect for decodes presented in the cycle right after the write.
- R12: Offsets outside both window regions (for example 0x080 and 0x960) read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's reg_addr |
| cpu_valid | input | 1 | CPU address valid |
| cpu_addr | input | 32 | CPU address to decode |
| dec_valid | output | 1 | Decode result valid |
| dec_miss | output | 1 | No window matched |
| dec_target | output | 4 | Target code of the selected window |
| dec_attr | output | 8 | Attribute of the selected window |
| dec_addr | output | 32 | Downstream address, translated or passed through |

## Verification
Each decode result and each read value is due exactly one clock edge after its stimulus. A register write is visible to a decode presented on the next cycle, so the translated result of that decode arrives one cycle after that. The bench drives inputs on the falling edge and samples on the following falling edge, which places each check a single rising edge after its stimulus. The write-then-use scenario drives the write and the dependent decode on back-to-back falling edges, so the one-cycle visibility of R11 is checked and not hidden by slack.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;

    localparam int DEF_NUM_WIN   = 14;
    localparam int DEF_NUM_REMAP = 8;
    localparam int DEF_REG_AW    = 12;
    localparam int DEF_HI_OFFSET = 'h900;

    // Word select inside a 16-byte window slot (reg_addr[3:2])
    typedef enum logic [1:0] {
        WORD_CTRL     = 2'd0,
        WORD_BASE     = 2'd1,
        WORD_XLATE_LO = 2'd2,
        WORD_XLATE_HI = 2'd3
    } win_word_e;

    typedef struct packed {
        logic [15:0] size_m1;
        logic [7:0]  attr;
        logic [3:0]  target;
        logic        en;
    } win_ctrl_t;

    typedef struct packed {
        win_ctrl_t   ctrl;
        logic [15:0] base;
        logic [15:0] xlate;
    } win_cfg_t;

    typedef struct packed {
        logic        hit;
        logic [3:0]  target;
        logic [7:0]  attr;
        logic [31:0] addr;
    } dec_result_t;

    function automatic logic [31:0] ctrl_to_word(input win_ctrl_t c);
        return {c.size_m1, c.attr, c.target, 3'b000, c.en};
    endfunction

    function automatic win_ctrl_t word_to_ctrl(input logic [31:0] w);
        win_ctrl_t c;
        c.size_m1 = w[31:16];
        c.attr    = w[15:8];
        c.target  = w[7:4];
        c.en      = w[0];
        return c;
    endfunction

endpackage

// File: rtl/addr_win_regs.sv
module addr_win_regs
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = DEF_NUM_WIN,
    parameter int NUM_REMAP = DEF_NUM_REMAP,
    parameter int REG_AW    = DEF_REG_AW,
    parameter int HI_OFFSET = DEF_HI_OFFSET
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          reg_wr,
    input  logic [REG_AW-1:0]             reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    output win_cfg_t [NUM_WIN-1:0]        cfg
);

    localparam int WIN_IW  = $clog2(NUM_WIN);
    localparam int SLOT_B  = 16;
    localparam int LO_END  = NUM_REMAP * SLOT_B;
    localparam int HI_END  = HI_OFFSET + (NUM_WIN - NUM_REMAP) * SLOT_B;

    logic              sel_ok;
    logic [WIN_IW-1:0] sel_win;
    win_word_e         sel_word;
    logic [NUM_WIN-1:0][3:0][31:0] rd_words;

    always_comb begin
        int ra;
        ra       = int'(reg_addr);
        sel_ok   = 1'b0;
        sel_win  = '0;
        sel_word = win_word_e'(reg_addr[3:2]);
        if (ra < LO_END) begin
            sel_ok  = 1'b1;
            sel_win = WIN_IW'(ra / SLOT_B);
        end else if (ra >= HI_OFFSET && ra < HI_END) begin
            sel_ok  = 1'b1;
            sel_win = WIN_IW'((ra - HI_OFFSET) / SLOT_B + NUM_REMAP);
        end
    end

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
        logic      hit_w;
        win_ctrl_t ctrl_q;
        logic [15:0] base_q;

        assign hit_w = reg_wr && sel_ok && (sel_win == WIN_IW'(n));

        always_ff @(posedge clk) begin
            if (rst) begin
                ctrl_q <= '0;
                base_q <= '0;
            end else if (hit_w && sel_word == WORD_CTRL) begin
                ctrl_q <= word_to_ctrl(reg_wdata);
            end else if (hit_w && sel_word == WORD_BASE) begin
                base_q <= reg_wdata[31:16];
            end
        end

        assign cfg[n].ctrl = ctrl_q;
        assign cfg[n].base = base_q;
        assign rd_words[n][WORD_CTRL] = ctrl_to_word(ctrl_q);
        assign rd_words[n][WORD_BASE] = {base_q, 16'h0};

        if (n < NUM_REMAP) begin : g_xlate
            logic [15:0] xlo_q;
            logic [31:0] xhi_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    xlo_q <= '0;
                    xhi_q <= '0;
                end else if (hit_w && sel_word == WORD_XLATE_LO) begin
                    xlo_q <= reg_wdata[31:16];
                end else if (hit_w && sel_word == WORD_XLATE_HI) begin
                    xhi_q <= reg_wdata;
                end
            end
            assign cfg[n].xlate             = xlo_q;
            assign rd_words[n][WORD_XLATE_LO] = {xlo_q, 16'h0};
            assign rd_words[n][WORD_XLATE_HI] = xhi_q;
        end else begin : g_no_xlate
            assign cfg[n].xlate             = '0;
            assign rd_words[n][WORD_XLATE_LO] = '0;
            assign rd_words[n][WORD_XLATE_HI] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else begin
            reg_rdata <= sel_ok ? rd_words[sel_win][sel_word] : 32'h0;
        end
    end

    logic unused_lsb;
    assign unused_lsb = ^reg_addr[1:0];

endmodule

// File: rtl/addr_win_match.sv
module addr_win_match
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = DEF_NUM_WIN,
    parameter int NUM_REMAP = DEF_NUM_REMAP
) (
    input  win_cfg_t [NUM_WIN-1:0] cfg,
    input  logic [31:0]            addr,
    output dec_result_t            res
);

    logic [NUM_WIN-1:0]       hit;
    logic [NUM_WIN-1:0][15:0] out_hi;

    for (genvar n = 0; n < NUM_WIN; n++) begin : g_cmp
        assign hit[n] = cfg[n].ctrl.en &&
                        (((addr[31:16] ^ cfg[n].base) & ~cfg[n].ctrl.size_m1) == 16'h0);
        if (n < NUM_REMAP) begin : g_xl
            assign out_hi[n] = (cfg[n].xlate & ~cfg[n].ctrl.size_m1) |
                               (addr[31:16] & cfg[n].ctrl.size_m1);
        end else begin : g_pass
            assign out_hi[n] = addr[31:16];
        end
    end

    // Scan from the top so the lowest-numbered hit overwrites last
    always_comb begin
        res = '{hit: 1'b0, target: 4'h0, attr: 8'h0, addr: addr};
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                res = '{hit: 1'b1, target: cfg[i].ctrl.target,
                        attr: cfg[i].ctrl.attr, addr: {out_hi[i], addr[15:0]}};
            end
        end
    end

    logic unused_cfg;
    assign unused_cfg = ^cfg;

endmodule

// File: rtl/addr_decode_windows.sv
module addr_decode_windows
    import addr_win_pkg::*;
#(
    parameter int NUM_WIN   = DEF_NUM_WIN,
    parameter int NUM_REMAP = DEF_NUM_REMAP,
    parameter int REG_AW    = DEF_REG_AW,
    parameter int HI_OFFSET = DEF_HI_OFFSET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              cpu_valid,
    input  logic [31:0]       cpu_addr,
    output logic              dec_valid,
    output logic              dec_miss,
    output logic [3:0]        dec_target,
    output logic [7:0]        dec_attr,
    output logic [31:0]       dec_addr
);

    win_cfg_t [NUM_WIN-1:0] cfg;
    dec_result_t            res;

    addr_win_regs #(
        .NUM_WIN  (NUM_WIN),
        .NUM_REMAP(NUM_REMAP),
        .REG_AW   (REG_AW),
        .HI_OFFSET(HI_OFFSET)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .cfg      (cfg)
    );

    addr_win_match #(
        .NUM_WIN  (NUM_WIN),
        .NUM_REMAP(NUM_REMAP)
    ) u_match (
        .cfg (cfg),
        .addr(cpu_addr),
        .res (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_miss   <= 1'b0;
            dec_target <= '0;
            dec_attr   <= '0;
            dec_addr   <= '0;
        end else begin
            dec_valid  <= cpu_valid;
            dec_miss   <= cpu_valid && !res.hit;
            dec_target <= res.target;
            dec_attr   <= res.attr;
            dec_addr   <= res.addr;
        end
    end

endmodule

// File: rtl/addr_decode_windows_chk.sv
module addr_decode_windows_chk (
    input logic        clk,
    input logic        rst,
    input logic        cpu_valid,
    input logic [31:0] cpu_addr,
    input logic        dec_valid,
    input logic        dec_miss,
    input logic [3:0]  dec_target,
    input logic [7:0]  dec_attr,
    input logic [31:0] dec_addr,
    input logic [31:0] reg_rdata
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!dec_valid && !dec_miss && reg_rdata == 32'h0));

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |=> dec_valid);

    assert_idle_follows_R10: assert property (@(posedge clk) disable iff (rst)
        !cpu_valid |=> !dec_valid);

    assert_miss_zero_fields_R7: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_miss) |-> (dec_target == 4'h0 && dec_attr == 8'h0));

    assert_miss_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |=> (!dec_miss || dec_addr == $past(cpu_addr)));

    assert_low_half_kept_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_valid |=> (dec_addr[15:0] == $past(cpu_addr[15:0])));

endmodule

bind addr_decode_windows addr_decode_windows_chk u_chk (.*);

// File: tb/test_addr_decode_windows.sv
`timescale 1ns/1ps
module test_addr_decode_windows;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        cpu_valid;
    logic [31:0] cpu_addr;
    logic        dec_valid;
    logic        dec_miss;
    logic [3:0]  dec_target;
    logic [7:0]  dec_attr;
    logic [31:0] dec_addr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    addr_decode_windows i_addr_decode_windows (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_valid(cpu_valid),
        .cpu_addr(cpu_addr), .dec_valid(dec_valid), .dec_miss(dec_miss),
        .dec_target(dec_target), .dec_attr(dec_attr), .dec_addr(dec_addr)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        chk(reg_rdata == exp, tag, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    task automatic look(input logic [31:0] a, input bit miss, input logic [3:0] tgt,
                        input logic [7:0] attr, input logic [31:0] oa, input string tag);
        logic [44:0] act, exp;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a;
        @(negedge clk);
        act = {dec_valid, dec_miss, dec_target, dec_attr, dec_addr[30:0]};
        exp = {1'b1, miss, tgt, attr, oa[30:0]};
        chk(act == exp && dec_addr[31] == oa[31], tag,
            {19'h0, dec_valid, dec_miss, dec_target, dec_attr, dec_addr},
            {19'h0, 1'b1, miss, tgt, attr, oa});
        cpu_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(dec_valid == 1'b0 && dec_miss == 1'b0, "R1 outputs idle after reset",
            {62'h0, dec_valid, dec_miss}, 64'h0);
        rd_chk(12'h000, 32'h0, "R1 win0 ctrl zero");
        rd_chk(12'h078, 32'h0, "R1 win7 xlate-lo zero");
        rd_chk(12'h954, 32'h0, "R1 win13 base zero");
    endtask

    task automatic t_offsets;
        wr(12'h074, 32'h7700_0000);
        wr(12'h904, 32'h8800_0000);
        wr(12'h954, 32'hD000_0000);
        rd_chk(12'h074, 32'h7700_0000, "R2 win7 base offset");
        rd_chk(12'h904, 32'h8800_0000, "R2 win8 base offset");
        rd_chk(12'h954, 32'hD000_0000, "R2 win13 base offset");
        wr(12'h074, 32'h0); wr(12'h904, 32'h0); wr(12'h954, 32'h0);
    endtask

    task automatic t_fields;
        wr(12'h040, 32'hFFFF_FFFF);
        wr(12'h044, 32'h1234_5678);
        wr(12'h048, 32'h8765_4321);
        wr(12'h04C, 32'hDEAD_BEEF);
        rd_chk(12'h040, 32'hFFFF_FFF1, "R3 ctrl bits 3:1 read zero");
        rd_chk(12'h044, 32'h1234_0000, "R3 base keeps 31:16");
        rd_chk(12'h048, 32'h8765_0000, "R3 xlate-lo keeps 31:16");
        rd_chk(12'h04C, 32'hDEAD_BEEF, "R3 xlate-hi full word");
        wr(12'h040, 32'h0);
    endtask

    task automatic t_remap;
        // window 0: base 0x1000_0000, 1 MB, target 4, attr 0xE0, moved to 0xA000_0000
        wr(12'h004, 32'h1000_0000);
        wr(12'h008, 32'hA000_0000);
        wr(12'h000, 32'h000F_E041);
        look(32'h1003_1234, 1'b0, 4'h4, 8'hE0, 32'hA003_1234, "R8 win0 translated");
        look(32'h100F_FFFF, 1'b0, 4'h4, 8'hE0, 32'hA00F_FFFF, "R4 win0 top edge hit");
        look(32'h1010_0000, 1'b1, 4'h0, 8'h00, 32'h1010_0000, "R4 just past win0 misses");
    endtask

    task automatic t_noremap;
        // window 9: base 0x2000_0000, 64 KB, target 1, attr 0x1D
        wr(12'h914, 32'h2000_0000);
        wr(12'h910, 32'h0000_1D11);
        wr(12'h918, 32'hFFFF_0000);
        wr(12'h91C, 32'hFFFF_FFFF);
        look(32'h2000_ABCD, 1'b0, 4'h1, 8'h1D, 32'h2000_ABCD, "R9 win9 passes address");
        rd_chk(12'h918, 32'h0, "R9 win9 xlate-lo write ignored");
        rd_chk(12'h95C, 32'h0, "R9 win13 xlate-hi reads zero");
    endtask

    task automatic t_priority;
        // window 2: 16 MB at 0x4000_0000, target 8 attr 0xF8, identity translation
        wr(12'h024, 32'h4000_0000);
        wr(12'h028, 32'h4000_0000);
        wr(12'h020, 32'h00FF_F881);
        // window 3: 64 KB at 0x4010_0000, target 0 attr 0x0E, xlate-lo left zero
        wr(12'h034, 32'h4010_0000);
        wr(12'h030, 32'h0000_0E01);
        look(32'h4010_0004, 1'b0, 4'h8, 8'hF8, 32'h4010_0004, "R6 lower window wins");
        wr(12'h020, 32'h0);
        look(32'h4010_0004, 1'b0, 4'h0, 8'h0E, 32'h0000_0004, "R6 next window after disable");
    endtask

    task automatic t_disabled;
        wr(12'h054, 32'h5000_0000);
        wr(12'h050, 32'h0000_0140);
        look(32'h5000_0000, 1'b1, 4'h0, 8'h00, 32'h5000_0000, "R5 enable=0 never hits");
    endtask

    task automatic t_miss;
        look(32'hF000_1234, 1'b1, 4'h0, 8'h00, 32'hF000_1234, "R7 unmatched address");
    endtask

    task automatic t_unmapped;
        wr(12'h080, 32'hFFFF_FFF1);
        wr(12'h960, 32'hFFFF_FFF1);
        rd_chk(12'h080, 32'h0, "R12 0x080 reads zero");
        rd_chk(12'h960, 32'h0, "R12 0x960 reads zero");
        look(32'hF000_0000, 1'b1, 4'h0, 8'h00, 32'hF000_0000, "R12 write created no window");
    endtask

    task automatic t_latency;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = 32'h1000_0000;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(dec_valid == 1'b1, "R10 valid one cycle later", {63'h0, dec_valid}, 64'h1);
        @(negedge clk);
        chk(dec_valid == 1'b0, "R10 valid drops one cycle later", {63'h0, dec_valid}, 64'h0);
    endtask

    task automatic t_write_use;
        // window 6: base 0x6000_0000 translated to 0x7000_0000, enabled last
        wr(12'h064, 32'h6000_0000);
        wr(12'h068, 32'h7000_0000);
        look(32'h6000_0010, 1'b1, 4'h0, 8'h00, 32'h6000_0010, "R11 miss before enable");
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h060; reg_wdata = 32'h0000_3381;
        @(negedge clk);
        reg_wr = 1'b0;
        cpu_valid = 1'b1; cpu_addr = 32'h6000_0010;
        @(negedge clk);
        cpu_valid = 1'b0;
        chk(dec_valid && !dec_miss && dec_target == 4'h8 && dec_attr == 8'h33 &&
            dec_addr == 32'h7000_0010, "R11 write used next cycle",
            {19'h0, dec_valid, dec_miss, dec_target, dec_attr, dec_addr},
            {19'h0, 1'b1, 1'b0, 4'h8, 8'h33, 32'h7000_0010});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        cpu_valid = 1'b0; cpu_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_offsets();
        t_fields();
        t_remap();
        t_noremap();
        t_priority();
        t_disabled();
        t_miss();
        t_unmapped();
        t_latency();
        t_write_use();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule